// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Ready/Empty Status

This block is the transmit half of an asynchronous serial port. A CPU-side write strobe places a byte in a one-entry holding register. Whenever the transmitter is enabled and the shifter is idle, that byte moves into a shift register and goes out on the serial line as a framed character. Because of the holding register, software can queue the next byte while the current one is still being sent. Characters then follow one another with no idle time on the line.

Two status outputs report on the two stages separately. `tx_ready` says the holding register can take a byte. `tx_empty` says the whole transmitter has drained. The transmitter is switched on and off by a two-bit command field. Switching it on discards anything left in the holding register. Switching it off aborts the frame in flight, and any byte written while the transmitter is off is never sent. Bit timing comes from an external baud tick; each serial bit lasts a fixed number of ticks.

Top module: `uart_txd_top`

## Requirements
- R1: After reset the transmitter is disabled: `txd`=1, `tx_ready`=0, `tx_empty`=0.
- R2: Command value 2'b01 (enable), issued while disabled, enables the transmitter and empties the holding register. From the next cycle `tx_ready`=1, and `tx_empty`=1 if the shifter is idle. Enable while already enabled has no effect.
- R3: Command value 2'b10 (disable) clears `tx_ready` and `tx_empty` from the next cycle. It aborts any frame in progress, returns `txd` high and empties the holding register.
- R4: A write while enabled clears `tx_ready` on the next cycle. If the shifter is idle, the byte moves to the shifter one cycle later and `tx_ready` returns to 1.
- R5: A frame is one start bit (0), DATA_W data bits least significant first, and one stop bit (1). Each bit lasts TICKS_PER_BIT baud ticks, counted from the load. `txd` is 1 whenever no frame is in progress.
- R6: `tx_empty` is 1 exactly when the transmitter is enabled, the holding register is empty and the shifter is idle. It rises on the cycle after the last tick of a stop bit when no byte is waiting.
- R7: If a byte is waiting when a stop bit ends, the next start bit begins on the very next cycle. `tx_empty` stays 0 in between.
- R8: A byte written while disabled is never transmitted, even after a later enable.
- R9: A write while `tx_ready`=0 replaces the held byte; only the latest one is sent.
- R10: A write in the same cycle as command 2'b01 or 2'b10 is discarded. Command values 2'b00 and 2'b11 take no action and do not block writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to be transmitted |
| cmd | input | 2 | Command: 01 enable, 10 disable, 00/11 no action |
| baud_tick | input | 1 | One-cycle pulse at the oversampled baud rate |
| txd | output | 1 | Serial line, idles high |
| tx_ready | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding register and shifter both empty while enabled |

## Verification
The bench builds the block with DATA_W=8 and TICKS_PER_BIT=4. It issues a baud tick every third clock, so a whole frame takes 120 cycles. These short frames put many frame boundaries within a run: back-to-back handoff at the stop bit, writes landing in the same cycle as a load, and disables at arbitrary bit positions. A behavioural model compares the line and both flags on every cycle, under directed sequences and a long random mix of writes and commands.

// File: rtl/uart_txd_pkg.sv
package uart_txd_pkg;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_ENABLE  = 2'b01,
        CMD_DISABLE = 2'b10,
        CMD_SPARE   = 2'b11
    } tx_cmd_e;

    typedef struct packed {
        logic turn_on;
        logic turn_off;
        logic store;
    } tx_ctl_t;

    // A command cycle swallows a coincident write.
    function automatic tx_ctl_t decode_ctl(input logic [1:0] cmd, input logic wr);
        tx_ctl_t c;
        c.turn_on  = (cmd == CMD_ENABLE);
        c.turn_off = (cmd == CMD_DISABLE);
        c.store    = wr && !c.turn_on && !c.turn_off;
        return c;
    endfunction

endpackage

// File: rtl/uart_txd_hold.sv
module uart_txd_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              store,
    input  logic [DATA_W-1:0] store_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            full <= 1'b0;
        end else if (store) begin
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (store && !flush) begin
            data <= store_data;
        end
    end

    // R9: a store always leaves the register occupied
    a_r9_store_fills: assert property (@(posedge clk) disable iff (rst)
        (store && !flush) |=> full);

endmodule

// File: rtl/uart_txd_shift.sv
module uart_txd_shift #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              baud_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              txd,
    output logic              busy,
    output logic              done
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int TK_W    = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam logic [TK_W-1:0]  TK_LAST  = TK_W'(TICKS_PER_BIT - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] sh;
    logic [TK_W-1:0]    tk;
    logic [BIT_W-1:0]   bit_idx;
    logic               bit_end;

    assign bit_end = busy && baud_tick && (tk == TK_LAST);
    assign done    = bit_end && (bit_idx == BIT_LAST);
    assign txd     = sh[0];

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy    <= 1'b0;
            sh      <= '1;
            tk      <= '0;
            bit_idx <= '0;
        end else if (load) begin
            busy    <= 1'b1;
            sh      <= {1'b1, load_data, 1'b0};
            tk      <= '0;
            bit_idx <= '0;
        end else if (busy && baud_tick) begin
            if (bit_end) begin
                tk <= '0;
                if (bit_idx == BIT_LAST) begin
                    busy <= 1'b0;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                    sh      <= {1'b1, sh[FRAME_W-1:1]};
                end
            end else begin
                tk <= tk + 1'b1;
            end
        end
    end

    // R5: every frame opens with a low start bit
    a_r5_start_low: assert property (@(posedge clk) disable iff (rst)
        (load && !abort) |=> !txd);
    // R5: line rests high between frames
    a_r5_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);
    // R3: an abort silences the line on the next cycle
    a_r3_abort_high: assert property (@(posedge clk) disable iff (rst)
        abort |=> (txd && !busy));

endmodule

// File: rtl/uart_txd_top.sv
module uart_txd_top #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        cmd,
    input  logic              baud_tick,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty
);
    import uart_txd_pkg::*;

    tx_ctl_t           ctl;
    logic              enabled;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              sh_busy;
    logic              sh_done;
    logic              take;
    logic              flush;

    assign ctl   = decode_ctl(cmd, wr_stb);
    assign flush = ctl.turn_off || (ctl.turn_on && !enabled);
    assign take  = enabled && hold_full && (!sh_busy || sh_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled <= 1'b0;
        end else if (ctl.turn_on) begin
            enabled <= 1'b1;
        end else if (ctl.turn_off) begin
            enabled <= 1'b0;
        end
    end

    uart_txd_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .store      (ctl.store),
        .store_data (wr_data),
        .take       (take),
        .full       (hold_full),
        .data       (hold_data)
    );

    uart_txd_shift #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .abort     (ctl.turn_off),
        .baud_tick (baud_tick),
        .load      (take),
        .load_data (hold_data),
        .txd       (txd),
        .busy      (sh_busy),
        .done      (sh_done)
    );

    assign tx_ready = enabled && !hold_full;
    assign tx_empty = enabled && !hold_full && !sh_busy;

    // R2: enabling from the off state frees the holding register
    a_r2_enable_ready: assert property (@(posedge clk) disable iff (rst)
        (ctl.turn_on && !enabled) |=> tx_ready);
    // R3: disabling drops both flags
    a_r3_disable_flags: assert property (@(posedge clk) disable iff (rst)
        ctl.turn_off |=> (!tx_ready && !tx_empty));
    // R4: an accepted write while enabled occupies the holding register
    a_r4_write_busy: assert property (@(posedge clk) disable iff (rst)
        (ctl.store && enabled) |=> !tx_ready);
    // R6: drained implies ready
    a_r6_empty_ready: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> tx_ready);
    // R6: drained status only appears at a frame end or on enable
    a_r6_empty_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_empty) |-> ($past(baud_tick) || $past(cmd) == CMD_ENABLE));
    // R8: nothing is sent while off
    a_r8_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (!enabled && !$past(enabled)) |-> txd);

endmodule

// File: tb/uart_txd_top_tb.sv
module uart_txd_top_tb;

    localparam int DW = 8;
    localparam int TPB = 4;
    localparam int NB = DW + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_stb = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    cmd = 2'b00;
    logic          baud_tick;
    logic          txd, tx_ready, tx_empty;

    int n_checks = 0;
    int n_fail = 0;
    int tdiv = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    uart_txd_top #(.DATA_W(DW), .TICKS_PER_BIT(TPB)) u_dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
        .cmd(cmd), .baud_tick(baud_tick),
        .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
    );

    always @(negedge clk) tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
    assign baud_tick = (tdiv == 0);

    // behavioural reference
    bit m_en, m_hf, m_busy, m_ld;
    bit [DW-1:0] m_hd, m_cur;
    int m_bit, m_tk;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_hf = 0; m_busy = 0; m_hd = 0; m_cur = 0; m_bit = 0; m_tk = 0;
        end else begin
            m_ld = 0;
            if (cmd == 2'b01 && !m_en) begin
                m_en = 1; m_hf = 0;
            end else if (cmd == 2'b10) begin
                m_en = 0; m_hf = 0; m_busy = 0;
            end else begin
                if (m_busy && baud_tick) begin
                    if (m_tk == TPB - 1) begin
                        m_tk = 0;
                        if (m_bit == NB - 1) begin
                            if (m_hf && m_en) m_ld = 1; else m_busy = 0;
                        end else m_bit++;
                    end else m_tk++;
                end else if (!m_busy && m_hf && m_en) m_ld = 1;
                if (m_ld) begin
                    m_busy = 1; m_cur = m_hd; m_bit = 0; m_tk = 0; m_hf = 0;
                end
                if (wr_stb && cmd != 2'b01 && cmd != 2'b10) begin
                    m_hf = 1; m_hd = wr_data;
                end
            end
        end
    end

    function automatic bit m_txd();
        if (!m_busy) return 1'b1;
        if (m_bit == 0) return 1'b0;
        if (m_bit == NB - 1) return 1'b1;
        return m_cur[m_bit-1];
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R5 txd", txd, m_txd());
            check("R4 tx_ready", tx_ready, m_en && !m_hf);
            check("R6 tx_empty", tx_empty, m_en && !m_hf && !m_busy);
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_cmd(logic [1:0] c);
        cmd = c; cyc(1); cmd = 2'b00;
    endtask

    task automatic do_wr(logic [DW-1:0] d);
        wr_stb = 1'b1; wr_data = d; cyc(1); wr_stb = 1'b0;
    endtask

    int lows;
    bit saw_empty;

    initial begin
        cyc(3);
        rst = 1'b0;
        // R1 (checked before any command can act)
        check("R1 txd", txd, 1'b1);
        check("R1 tx_ready", tx_ready, 1'b0);
        check("R1 tx_empty", tx_empty, 1'b0);

        // R8: byte written while off
        do_wr(8'hA5);
        check("R8 ready off", tx_ready, 1'b0);
        do_cmd(2'b01);
        // R2
        check("R2 ready", tx_ready, 1'b1);
        check("R2 empty", tx_empty, 1'b1);
        lows = 0;
        for (int i = 0; i < 200; i++) begin cyc(1); if (!txd) lows++; end
        check("R8 no frame", lows == 0, 1'b1);

        // R4 handoff timing
        do_wr(8'h3C);
        check("R4 ready low", tx_ready, 1'b0);
        check("R6 empty low", tx_empty, 1'b0);
        cyc(1);
        check("R4 ready back", tx_ready, 1'b1);
        check("R5 start bit", txd, 1'b0);
        while (!tx_empty) cyc(1);

        // R7 back-to-back and R9 overwrite
        do_wr(8'h81);
        cyc(1);
        do_wr(8'h7E);
        do_wr(8'h55);
        check("R9 ready held", tx_ready, 1'b0);
        saw_empty = 0;
        for (int i = 0; i < 2 * NB * TPB * 3 - 10; i++) begin
            cyc(1); if (tx_empty) saw_empty = 1;
        end
        check("R7 no gap", saw_empty, 1'b0);
        while (!tx_empty) cyc(1);

        // R3 abort mid-frame
        do_wr(8'h0F);
        cyc(25);
        do_wr(8'hF0);
        do_cmd(2'b10);
        check("R3 txd", txd, 1'b1);
        check("R3 ready", tx_ready, 1'b0);
        check("R3 empty", tx_empty, 1'b0);

        // R10: write with enable is dropped
        cmd = 2'b01; wr_stb = 1'b1; wr_data = 8'hEE; cyc(1);
        cmd = 2'b00; wr_stb = 1'b0;
        check("R10 drop on enable", tx_ready, 1'b1);
        // R10: spare command lets a write through
        cmd = 2'b11; wr_stb = 1'b1; wr_data = 8'h99; cyc(1);
        cmd = 2'b00; wr_stb = 1'b0;
        check("R10 spare cmd", tx_ready, 1'b0);
        while (!tx_empty) cyc(1);

        // random mix
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 199);
            wr_stb = (r < 12);
            wr_data = 8'($urandom);
            cmd = (r == 100) ? 2'b10 : (r >= 101 && r < 104) ? 2'b01 :
                  (r == 104) ? 2'b11 : 2'b00;
            cyc(1);
        end
        wr_stb = 1'b0; cmd = 2'b00;
        cyc(5);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule